// File: doc/BRIEF.md
# Charger Host Register Port with Watchdog

This block is the host-facing register port of a battery charger controller. It acts as a two-wire serial (I2C) target on oversampled clock and data lines, answering to the fixed 7-bit address 0x6B. Behind it sits a file of 21 byte-wide locations at addresses 0x00 through 0x14. Most locations hold configuration that is presented in parallel to the charger core. A few locations mirror status bytes that the core supplies. One location reports latched faults and tells the fault logic, through a one-cycle strobe, whenever the host has fetched it.

A host-liveness watchdog counts one-second ticks. If the host does not restart it within the selected timeout, the configuration falls back to its power-up values. Three fields are spared: the input current limit, the input voltage limit and the voltage-limit offset. A flag in the fault byte records the expiry. Two command bits clear themselves after use: one reloads every default and one restarts the watchdog. A third bit, which requests source detection, is cleared when the core reports that detection has finished.

Top module: `chg_i2c_regs`

## Requirements
- R1: The block acknowledges a first byte whose upper seven bits equal 0x6B (bit 0 = 1 selects read, 0 selects write). Any other address gets no acknowledge. Bytes travel most significant bit first, with an acknowledge slot after each one.
- R2: START (data falls while clock is high) begins a transfer and STOP (data rises while clock is high) ends it. A repeated START keeps the register pointer, so the host can write a pointer and then read. The block changes its data drive only while the clock line is low.
- R3: A register-pointer byte above 0x14 is not acknowledged, and the block then ignores the bus until the next START.
- R4: After each data byte of a read or a write, the pointer advances by one. A read at a pointer above 0x14 returns 0xFF.
- R5: Location 0x0C (the fault byte) allows single access only. In a burst, every access after 0x0C returns 0xFF and every write after it is refused. Each fetch of 0x0C pulses `fault_rd` for one cycle.
- R6: Writes change only writable bits. Reserved and read-only bits keep fixed values: 0x00 bit 6 reads 1 and 0x07 bit 0 reads 1. Writable masks are 0x00:BF, 0x01:01, 0x02:C3, 0x03:BE, 0x04:3F, 0x07:FE, and FF for 0x05, 0x06, 0x08, 0x09, 0x0A and 0x0D. Locations 0x0B and 0x0E to 0x13 return `status_in` bytes 0 to 6 (byte k at bits 8k+7:8k) and ignore writes.
- R7: Field 0x07[5:4] selects the watchdog timeout: 00 disables it, 01 = 40 ticks, 10 = 80 ticks and 11 = 160 ticks. A tick is TICK_CYCLES clocks.
- R8: Writing 1 to 0x03 bit 6 restarts the watchdog, and that bit always reads 0.
- R9: On watchdog expiry, every location returns to its default except 0x00[5:0], 0x01[0] and all of 0x0D. Bit 7 of 0x0C then reads 1 until the first fetch of 0x0C after the expiry.
- R10: Writing 1 to 0x14 bit 7 reloads every default, including the fields spared by R9. The bit always reads 0.
- R11: Bit 1 of 0x02 (detection request) is cleared by a `detect_done` pulse.
- R12: After reset `cfg_out` holds the defaults, byte a at bits 8a+7:8a. The defaults are 0x00=5C, 0x01=01, 0x02=01, 0x03=1A, 0x05=13, 0x06=5E, 0x07=9D, 0x08=03, 0x09=44, 0x0A=73, 0x0D=12, 0x14=02, and 00 for the rest. `sda_oe` is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| detect_done | input | 1 | Pulse from the core: source detection finished |
| status_in | input | 56 | Seven status bytes mirrored at 0x0B and 0x0E to 0x13 |
| fault_in | input | 8 | Fault byte from the fault logic; bit 7 is ORed with the watchdog flag |
| fault_rd | output | 1 | One-cycle pulse when 0x0C is fetched |
| cfg_out | output | 168 | All 21 locations, byte a at bits 8a+7:8a |

## Verification
The bench builds the block with TICK_CYCLES set to 200. This puts the 40-tick and 80-tick timeouts at 8,000 and 16,000 clocks, short enough that the bench can observe expiry in both settings, the disabled setting, and the partial reload. The serial clock half-period is 8 system clocks, which leaves room for the two-stage synchroniser and edge detector. Bursts are run through the top of the map, across the fault byte, and across the 0x14 boundary.

// File: rtl/chg_i2c_pkg.sv
package chg_i2c_pkg;
  localparam int NREG = 21;
  localparam int NSTAT = 7;
  localparam logic [7:0] LAST_ADDR = 8'h14;
  localparam logic [7:0] FAULT_ADDR = 8'h0C;
  localparam logic [7:0] BAD_PTR = 8'hFF;
  localparam int WDCFG_ADDR = 7;
  localparam int WDSEL_LSB = 4;
  localparam int KICK_ADDR = 3;
  localparam int KICK_BIT = 6;
  localparam int RELOAD_ADDR = 20;
  localparam int RELOAD_BIT = 7;
  localparam int DET_ADDR = 2;
  localparam int DET_BIT = 1;

  typedef enum logic [2:0] {L_IDLE, L_RX, L_ACK, L_TX, L_RACK} link_st_e;
  typedef enum logic [1:0] {K_DEV, K_REG, K_DATA} byte_kind_e;

  function automatic logic [7:0] reg_dflt(input int a);
    case (a)
      0: return 8'h5C;
      1: return 8'h01;
      2: return 8'h01;
      3: return 8'h1A;
      5: return 8'h13;
      6: return 8'h5E;
      7: return 8'h9D;
      8: return 8'h03;
      9: return 8'h44;
      10: return 8'h73;
      13: return 8'h12;
      20: return 8'h02;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_wmask(input int a);
    case (a)
      0: return 8'hBF;
      1: return 8'h01;
      2: return 8'hC3;
      3: return 8'hBE;
      4: return 8'h3F;
      7: return 8'hFE;
      5, 6, 8, 9, 10, 13: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [7:0] reg_keep(input int a);
    case (a)
      0: return 8'h3F;
      1: return 8'h01;
      13: return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic int stat_slot(input logic [7:0] a);
    if (a == 8'h0B) return 0;
    if (a >= 8'h0E && a <= 8'h13) return int'(a) - 13;
    return -1;
  endfunction

  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    if (p == FAULT_ADDR || p > LAST_ADDR) return BAD_PTR;
    return p + 8'd1;
  endfunction
endpackage

// File: rtl/chg_i2c_sync.sv
module chg_i2c_sync (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_rise,
  output logic scl_fall,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);
  // [0],[1] synchroniser, [2] previous synchronised sample
  logic [2:0] scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[1:0], scl_in};
      sda_q <= {sda_q[1:0], sda_in};
    end
  end

  assign sda_s     = sda_q[1];
  assign scl_rise  = scl_q[1] & ~scl_q[2];
  assign scl_fall  = ~scl_q[1] & scl_q[2];
  assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
  assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/chg_i2c_link.sv
module chg_i2c_link
  import chg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6B
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_rise,
  input  logic       scl_fall,
  input  logic       sda_s,
  input  logic       start_det,
  input  logic       stop_det,
  input  logic [7:0] rd_data,
  output logic [7:0] rd_addr,
  output logic       sda_oe,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       fault_rd
);
  link_st_e   st;
  byte_kind_e kind;
  logic [3:0] cnt;
  logic [7:0] shr, txd, ptr;
  logic       is_rd, mack;

  assign rd_addr = ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= L_IDLE; kind <= K_DEV; cnt <= '0; shr <= '0; txd <= '0;
      ptr <= '0; is_rd <= 1'b0; mack <= 1'b0; sda_oe <= 1'b0;
      wr_en <= 1'b0; wr_addr <= '0; wr_data <= '0; fault_rd <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      fault_rd <= 1'b0;
      if (start_det) begin
        st <= L_RX; kind <= K_DEV; cnt <= '0; sda_oe <= 1'b0;
      end else if (stop_det) begin
        st <= L_IDLE; sda_oe <= 1'b0;
      end else begin
        case (st)
          L_RX: begin
            if (scl_rise) begin
              shr <= {shr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              cnt <= '0;
              case (kind)
                K_DEV: begin
                  if (shr[7:1] == DEV_ADDR) begin
                    sda_oe <= 1'b1; st <= L_ACK; is_rd <= shr[0]; kind <= K_REG;
                  end else st <= L_IDLE;
                end
                K_REG: begin
                  if (shr <= LAST_ADDR) begin
                    sda_oe <= 1'b1; st <= L_ACK; ptr <= shr; kind <= K_DATA;
                  end else st <= L_IDLE;
                end
                default: begin
                  if (ptr <= LAST_ADDR) begin
                    sda_oe <= 1'b1; st <= L_ACK;
                    wr_en <= 1'b1; wr_addr <= ptr; wr_data <= shr;
                    ptr <= ptr_next(ptr);
                  end else st <= L_IDLE;
                end
              endcase
            end
          end
          L_ACK: begin
            if (scl_fall) begin
              if (is_rd) begin
                txd <= rd_data; sda_oe <= ~rd_data[7];
                fault_rd <= (ptr == FAULT_ADDR);
                ptr <= ptr_next(ptr); cnt <= '0; st <= L_TX;
              end else begin
                sda_oe <= 1'b0; st <= L_RX;
              end
            end
          end
          L_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0; cnt <= '0; st <= L_RACK;
              end else begin
                cnt <= cnt + 4'd1;
                txd <= {txd[6:0], 1'b0};
                sda_oe <= ~txd[6];
              end
            end
          end
          L_RACK: begin
            if (scl_rise) mack <= ~sda_s;
            else if (scl_fall) begin
              if (mack) begin
                txd <= rd_data; sda_oe <= ~rd_data[7];
                fault_rd <= (ptr == FAULT_ADDR);
                ptr <= ptr_next(ptr); cnt <= '0; st <= L_TX;
              end else st <= L_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/chg_i2c_wdog.sv
module chg_i2c_wdog #(
  parameter int TICK_CYCLES = 100_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kick,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int TW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [TW-1:0] TICK_LAST = TW'(TICK_CYCLES - 1);

  logic [TW-1:0] tcnt;
  logic [7:0]    secs, limit;

  always_comb begin
    case (sel)
      2'b01: limit = 8'd40;
      2'b10: limit = 8'd80;
      2'b11: limit = 8'd160;
      default: limit = 8'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tcnt <= '0; secs <= '0; expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (kick || sel == 2'b00) begin
        tcnt <= '0; secs <= '0;
      end else if (tcnt == TICK_LAST) begin
        tcnt <= '0;
        if (secs >= limit - 8'd1) begin
          secs <= '0; expire <= 1'b1;
        end else secs <= secs + 8'd1;
      end else tcnt <= tcnt + 1'b1;
    end
  end
endmodule

// File: rtl/chg_i2c_regbank.sv
module chg_i2c_regbank
  import chg_i2c_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [7:0]           wr_addr,
  input  logic [7:0]           wr_data,
  input  logic [7:0]           rd_addr,
  input  logic                 fault_rd,
  input  logic                 detect_done,
  input  logic                 expire,
  input  logic [NSTAT*8-1:0]   status_in,
  input  logic [7:0]           fault_in,
  output logic [7:0]           rd_data,
  output logic [NREG*8-1:0]    cfg_out,
  output logic [1:0]           wd_sel,
  output logic                 kick
);
  logic [7:0] mem [NREG];
  logic       wd_fault;
  logic       reload;

  assign reload = wr_en && wr_addr == 8'(RELOAD_ADDR) && wr_data[RELOAD_BIT];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [7:0] DFLT = reg_dflt(g);
    localparam logic [7:0] WM   = reg_wmask(g);
    localparam logic [7:0] KEEP = reg_keep(g);
    always_ff @(posedge clk) begin
      if (rst || reload) mem[g] <= DFLT;
      else if (expire) mem[g] <= (mem[g] & KEEP) | (DFLT & ~KEEP);
      else if (wr_en && wr_addr == 8'(g)) mem[g] <= (mem[g] & ~WM) | (wr_data & WM);
      if (!rst && !reload && g == DET_ADDR && detect_done) mem[g][DET_BIT] <= 1'b0;
    end
    assign cfg_out[g*8 +: 8] = mem[g];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_fault <= 1'b0; kick <= 1'b0;
    end else begin
      kick <= reload || (wr_en && wr_addr == 8'(KICK_ADDR) && wr_data[KICK_BIT]);
      if (expire) wd_fault <= 1'b1;
      else if (fault_rd) wd_fault <= 1'b0;
    end
  end

  assign wd_sel = mem[WDCFG_ADDR][WDSEL_LSB +: 2];

  always_comb begin
    int slot;
    slot = stat_slot(rd_addr);
    if (rd_addr > LAST_ADDR) rd_data = 8'hFF;
    else if (rd_addr == FAULT_ADDR) rd_data = {wd_fault | fault_in[7], fault_in[6:0]};
    else if (slot >= 0) rd_data = status_in[slot*8 +: 8];
    else rd_data = mem[rd_addr[4:0]];
  end
endmodule

// File: rtl/chg_i2c_regs.sv
module chg_i2c_regs
  import chg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h6B,
  parameter int TICK_CYCLES = 100_000_000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         scl_in,
  input  logic         sda_in,
  output logic         sda_oe,
  input  logic         detect_done,
  input  logic [55:0]  status_in,
  input  logic [7:0]   fault_in,
  output logic         fault_rd,
  output logic [167:0] cfg_out
);
  logic scl_rise, scl_fall, sda_s, start_det, stop_det;
  logic [7:0] rd_data, rd_addr, wr_addr, wr_data;
  logic wr_en, expire, kick;
  logic [1:0] wd_sel;

  chg_i2c_sync u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
    .start_det(start_det), .stop_det(stop_det)
  );

  chg_i2c_link #(.DEV_ADDR(DEV_ADDR)) u_link (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .rd_data(rd_data), .rd_addr(rd_addr), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .fault_rd(fault_rd)
  );

  chg_i2c_regbank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .fault_rd(fault_rd), .detect_done(detect_done),
    .expire(expire), .status_in(status_in), .fault_in(fault_in),
    .rd_data(rd_data), .cfg_out(cfg_out), .wd_sel(wd_sel), .kick(kick)
  );

  chg_i2c_wdog #(.TICK_CYCLES(TICK_CYCLES)) u_wdog (
    .clk(clk), .rst(rst), .kick(kick), .sel(wd_sel), .expire(expire)
  );
endmodule

// File: rtl/chg_i2c_regs_chk.sv
module chg_i2c_regs_chk (
  input logic         clk,
  input logic         rst,
  input logic         scl_in,
  input logic         sda_oe,
  input logic         fault_rd,
  input logic         detect_done,
  input logic [167:0] cfg_out
);
  assert_sda_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_in);

  assert_fixed_bits_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_out[6] && cfg_out[56]);

  assert_status_ro_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_out[88 +: 8] == 8'h00);

  assert_rd_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    fault_rd |=> !fault_rd);

  assert_detect_clear_R11: assert property (@(posedge clk) disable iff (rst)
    detect_done |=> !cfg_out[17]);

  assert_reload_bit_R10: assert property (@(posedge clk) disable iff (rst)
    !cfg_out[167] && !cfg_out[30]);
endmodule

bind chg_i2c_regs chg_i2c_regs_chk u_chk (
  .clk(clk), .rst(rst), .scl_in(scl_in), .sda_oe(sda_oe),
  .fault_rd(fault_rd), .detect_done(detect_done), .cfg_out(cfg_out)
);

// File: tb/sim_chg_i2c_regs.sv
module sim_chg_i2c_regs;
  localparam int H = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic scl = 1'b1, sda_m = 1'b1, detect_done = 1'b0;
  logic sda_oe, fault_rd, sda_line;
  logic [55:0] status_in = 56'h66_55_44_33_22_11_C5;
  logic [7:0] fault_in = 8'h05;
  logic [167:0] cfg_out;
  int total = 0, fails = 0, rd_pulses = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  chg_i2c_regs #(.TICK_CYCLES(200)) u0 (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line), .sda_oe(sda_oe),
    .detect_done(detect_done), .status_in(status_in), .fault_in(fault_in),
    .fault_rd(fault_rd), .cfg_out(cfg_out)
  );

  always @(posedge clk) if (fault_rd) rd_pulses++;

  localparam logic [23:0] VEC [11] = '{
    24'h07_00_01, 24'h00_FF_FF, 24'h00_12_52, 24'h01_FE_00, 24'h04_FF_3F,
    24'h03_FF_BE, 24'h0B_AA_C5, 24'h0D_55_55, 24'h05_C3_C3, 24'h14_7F_02,
    24'h07_FF_FF };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic w(input int n); repeat (n) @(negedge clk); endtask

  task automatic i2c_start;
    sda_m = 1'b1; w(H); scl = 1'b1; w(H); sda_m = 1'b0; w(H); scl = 1'b0;
  endtask

  task automatic i2c_stop;
    sda_m = 1'b0; w(H); scl = 1'b1; w(H); sda_m = 1'b1; w(H);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic nack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(H); scl = 1'b1; w(H); scl = 1'b0;
    end
    sda_m = 1'b1; w(H); scl = 1'b1; w(H/2); nack = sda_line; w(H/2); scl = 1'b0;
  endtask

  task automatic rbyte(input logic ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; w(H); scl = 1'b1; w(H/2); b[i] = sda_line; w(H/2); scl = 1'b0;
    end
    sda_m = ~ack; w(H); scl = 1'b1; w(H); scl = 1'b0;
  endtask

  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    logic n;
    i2c_start; wbyte(8'hD6, n); wbyte(a, n); wbyte(d, n); i2c_stop;
  endtask

  task automatic rd1(input logic [7:0] a, output logic [7:0] d);
    logic n;
    i2c_start; wbyte(8'hD6, n); wbyte(a, n);
    i2c_start; wbyte(8'hD7, n); rbyte(1'b0, d); i2c_stop;
  endtask

  function automatic logic [7:0] cb(input int a);
    return cfg_out[a*8 +: 8];
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, d2, d3;
    logic n1, n2;
    w(5); rst = 1'b0; w(2);
    // R12 reset state
    chk("R12 cfg 0x00", cb(0), 8'h5C);
    chk("R12 cfg 0x07", cb(7), 8'h9D);
    chk("R12 cfg 0x14", cb(20), 8'h02);
    chk("R12 cfg 0x0D", cb(13), 8'h12);
    chk("R12 sda_oe", sda_oe, 1'b0);

    // R6 R8 R10 write masks, fixed bits, self-clearing bits via table
    for (int i = 0; i < 11; i++) begin
      wr1(VEC[i][23:16], VEC[i][15:8]);
      rd1(VEC[i][23:16], d);
      chk($sformatf("R6 table entry %0d", i), d, VEC[i][7:0]);
    end

    // R1 wrong device address
    i2c_start; wbyte(8'hD4, n1); i2c_stop;
    chk("R1 foreign address nack", n1, 1'b1);
    i2c_start; wbyte(8'hD6, n1); i2c_stop;
    chk("R1 own address ack", n1, 1'b0);

    // R3 pointer beyond map
    i2c_start; wbyte(8'hD6, n1); wbyte(8'h15, n2); i2c_stop;
    chk("R3 pointer 0x15 nack", n2, 1'b1);

    // R4 multi-write then multi-read
    i2c_start; wbyte(8'hD6, n1); wbyte(8'h08, n1);
    wbyte(8'h11, n1); wbyte(8'h22, n1); wbyte(8'h33, n2); i2c_stop;
    chk("R4 burst write ack", n2, 1'b0);
    i2c_start; wbyte(8'hD6, n1); wbyte(8'h08, n1);
    i2c_start; wbyte(8'hD7, n1);
    rbyte(1'b1, d); rbyte(1'b1, d2); rbyte(1'b0, d3); i2c_stop;
    chk("R4 burst read 0x08", d, 8'h11);
    chk("R4 burst read 0x09", d2, 8'h22);
    chk("R4 burst read 0x0A", d3, 8'h33);

    // R4 R2 read across end of map with repeated start
    i2c_start; wbyte(8'hD6, n1); wbyte(8'h13, n1);
    i2c_start; wbyte(8'hD7, n1);
    rbyte(1'b1, d); rbyte(1'b1, d2); rbyte(1'b0, d3); i2c_stop;
    chk("R6 status slot 6", d, 8'h66);
    chk("R4 read 0x14", d2, 8'h02);
    chk("R4 read past map", d3, 8'hFF);

    // R5 burst across fault byte
    rd_pulses = 0;
    i2c_start; wbyte(8'hD6, n1); wbyte(8'h0B, n1);
    i2c_start; wbyte(8'hD7, n1);
    rbyte(1'b1, d); rbyte(1'b1, d2); rbyte(1'b0, d3); i2c_stop;
    chk("R6 status slot 0", d, 8'hC5);
    chk("R5 fault byte", d2, 8'h05);
    chk("R5 after fault byte", d3, 8'hFF);
    chk("R5 fault_rd pulses", rd_pulses, 1);
    i2c_start; wbyte(8'hD6, n1); wbyte(8'h0C, n1); wbyte(8'h00, n1); wbyte(8'h00, n2); i2c_stop;
    chk("R5 write after fault byte refused", n2, 1'b1);

    // R11 detection request
    wr1(8'h02, 8'h03);
    chk("R11 request set", cb(2), 8'h03);
    @(negedge clk) detect_done = 1'b1; @(negedge clk) detect_done = 1'b0; w(1);
    chk("R11 request cleared", cb(2), 8'h01);

    // R10 reload of all defaults
    wr1(8'h0D, 8'h77);
    wr1(8'h14, 8'h80); w(2);
    chk("R10 reload 0x00", cb(0), 8'h5C);
    chk("R10 reload 0x0D", cb(13), 8'h12);
    chk("R10 reload 0x07", cb(7), 8'h9D);

    // R9 R7 R8 watchdog at 40 ticks
    wr1(8'h00, 8'hFF); wr1(8'h0D, 8'h77); wr1(8'h05, 8'h00);
    wr1(8'h03, 8'h40);
    w(6400);
    chk("R8 no expiry before 40 ticks", cb(5), 8'h00);
    w(2400);
    chk("R9 expiry resets 0x05", cb(5), 8'h13);
    chk("R9 expiry keeps limit in 0x00", cb(0), 8'h7F);
    chk("R9 expiry keeps 0x0D", cb(13), 8'h77);
    chk("R9 expiry resets 0x07", cb(7), 8'h9D);
    rd1(8'h0C, d); rd1(8'h0C, d2);
    chk("R9 fault flag first read", d, 8'h85);
    chk("R9 fault flag second read", d2, 8'h05);

    // R7 80-tick setting
    wr1(8'h05, 8'h00); wr1(8'h07, 8'hAD); wr1(8'h03, 8'h40);
    w(12000);
    chk("R7 80 ticks not yet", cb(5), 8'h00);
    w(5000);
    chk("R7 80 ticks expired", cb(5), 8'h13);

    // R7 disabled
    wr1(8'h07, 8'h8D); wr1(8'h05, 8'h00);
    w(9000);
    chk("R7 disabled no expiry", cb(5), 8'h00);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule